// File: doc/BRIEF.md
# SCL Clock Divider

This block derives the serial bus clock for an I2C controller from the system clock. Three counters are chained. The first counts the high-phase value THP and wraps after THP+1 cycles. The second is a power-of-two prescaler that wraps after 2^N of the first counter's wraps. The third divides by (M+1)×10. One SCL half period therefore lasts (THP+1)·2^N·(M+1)·10 system cycles, and the full SCL frequency is sys_clk / (2·(THP+1)) / 2^N / (M+1) / 10.

Besides the SCL level, the block produces two single-cycle pulses for the bus engine. One marks every half-period edge. The other marks the middle of each high phase, which is where the bus engine samples the data line.

The divisor fields are loaded through two byte-wide registers, selected by a single select bit. Both fields pass through a pending stage. The pending values are copied into the active divider only while the engine is disabled, or at the moment SCL rises to begin a new period. A reprogram therefore never cuts a period short. While the engine enable is low, every counter is cleared and SCL is released high.

Top module: `scl_div`

## Requirements
- R1: After reset the active settings are THP = 0x18, M = 2 and N = 0, which gives a half period of 750 cycles. While reset is held, SCL is high and both pulses are low.
- R2: Once the enable goes high, SCL stays high for H = (THP+1)·2^N·(M+1)·10 cycles and then toggles every H cycles. This holds for every N from 0 to 7 and every M from 0 to 15.
- R3: The edge pulse is high for exactly one cycle. That cycle is the first one in which SCL shows a new level after a half-period edge. The pulse never occurs without an SCL change while the divider is running.
- R4: The sample pulse is high for one cycle, H/2 cycles after each rising edge of SCL, and only while SCL is high.
- R5: The select bit chooses the target register. Select 0 writes the 8-bit THP value. Select 1 writes the control byte, with M in bits 6:3 and N in bits 2:0. Bit 7 of the control byte is ignored.
- R6: A THP value below 5 is treated as 5 by the divider.
- R7: Settings written while the divider runs take effect only when SCL next rises. The period in progress completes with its old timing.
- R8: Settings written while the enable is low take effect from the first cycle after the enable rises.
- R9: When the enable drops, SCL is high from the next cycle and no pulses are produced. Re-enabling restarts the timing from zero, with a full high phase first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| engine_en_i | input | 1 | Run enable from the bus engine; low clears the divider and releases SCL |
| cfg_wr_i | input | 1 | Register write strobe, one cycle per byte |
| cfg_sel_i | input | 1 | Register select: 0 = high-phase count, 1 = clock-control byte |
| cfg_data_i | input | 8 | Register write data |
| scl_o | output | 1 | SCL level, 1 = released high |
| edge_tick_o | output | 1 | One-cycle pulse at each SCL half-period edge |
| sample_tick_o | output | 1 | One-cycle pulse at the middle of each SCL high phase |

## Verification
The bench builds the block with its default parameters: 8-bit THP, 4-bit M, 3-bit N, a decade factor of 10 and a THP floor of 5. With these values the full field ranges can be written through the byte registers, including the extremes N = 7 and M = 15. The reset default of 750 cycles and the clamped minimum of THP = 5 (a 60-cycle half period) are both short enough to run over complete periods. Random configurations are kept below roughly two thousand cycles per half period. This leaves room for several reprograms made in the middle of a period, with each one observed across the old period and the new one.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;

  // register select encoding on the write port
  localparam logic SEL_HIGH_PHASE = 1'b0;
  localparam logic SEL_CLK_CTRL   = 1'b1;

  // level of the serial clock line
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

endpackage

// File: rtl/scl_div_rstsync.sv
`timescale 1ns/1ps
module scl_div_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/scl_div_cfg.sv
`timescale 1ns/1ps
module scl_div_cfg
  import scl_div_pkg::*;
#(
  parameter int THP_W   = 8,
  parameter int M_W     = 4,
  parameter int N_W     = 3,
  parameter int THP_MIN = 5,
  parameter int RST_THP = 'h18,
  parameter int RST_M   = 2,
  parameter int RST_N   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [7:0]       data_i,
  input  logic             load_i,
  output logic [THP_W-1:0] act_thp_o,
  output logic [M_W-1:0]   act_m_o,
  output logic [N_W-1:0]   act_n_o
);

  localparam int M_LSB = N_W;
  localparam int M_MSB = N_W + M_W - 1;
  localparam logic [THP_W-1:0] THP_FLOOR = THP_W'(THP_MIN);

  logic [THP_W-1:0] pend_thp_q, pend_thp_d;
  logic [M_W-1:0]   pend_m_q,   pend_m_d;
  logic [N_W-1:0]   pend_n_q,   pend_n_d;
  logic [THP_W-1:0] act_thp_q,  act_thp_d;
  logic [M_W-1:0]   act_m_q,    act_m_d;
  logic [N_W-1:0]   act_n_q,    act_n_d;
  logic [THP_W-1:0] thp_floored;

  // pending stage: host writes land here
  always_comb begin
    pend_thp_d = pend_thp_q;
    pend_m_d   = pend_m_q;
    pend_n_d   = pend_n_q;
    if (wr_i) begin
      if (sel_i == SEL_HIGH_PHASE) begin
        pend_thp_d = data_i[THP_W-1:0];
      end else begin
        pend_m_d = data_i[M_MSB:M_LSB];
        pend_n_d = data_i[N_W-1:0];
      end
    end
  end

  // values below the floor are raised to it before reaching the divider
  assign thp_floored = (pend_thp_q < THP_FLOOR) ? THP_FLOOR : pend_thp_q;

  // active stage: copied only at a load point
  always_comb begin
    act_thp_d = act_thp_q;
    act_m_d   = act_m_q;
    act_n_d   = act_n_q;
    if (load_i) begin
      act_thp_d = thp_floored;
      act_m_d   = pend_m_q;
      act_n_d   = pend_n_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_thp_q <= THP_W'(RST_THP);
      pend_m_q   <= M_W'(RST_M);
      pend_n_q   <= N_W'(RST_N);
      act_thp_q  <= THP_W'(RST_THP);
      act_m_q    <= M_W'(RST_M);
      act_n_q    <= N_W'(RST_N);
    end else begin
      pend_thp_q <= pend_thp_d;
      pend_m_q   <= pend_m_d;
      pend_n_q   <= pend_n_d;
      act_thp_q  <= act_thp_d;
      act_m_q    <= act_m_d;
      act_n_q    <= act_n_d;
    end
  end

  assign act_thp_o = act_thp_q;
  assign act_m_o   = act_m_q;
  assign act_n_o   = act_n_q;

endmodule

// File: rtl/scl_div_chain.sv
`timescale 1ns/1ps
module scl_div_chain #(
  parameter int THP_W = 8,
  parameter int M_W   = 4,
  parameter int N_W   = 3,
  parameter int DEC   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [THP_W-1:0] thp_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [N_W-1:0]   n_i,
  output logic             half_end_o,
  output logic             mid_hit_o
);

  localparam int PRE_W   = (1 << N_W) - 1;
  localparam int SEG_MAX = (1 << M_W) * DEC;
  localparam int SEG_W   = $clog2(SEG_MAX);
  localparam int HALF_DEC = DEC / 2;

  localparam logic [THP_W-1:0] THP_ONE = 1;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;
  localparam logic [SEG_W-1:0] SEG_ONE = 1;

  logic [THP_W-1:0] base_q, base_d;
  logic [PRE_W-1:0] pre_q,  pre_d;
  logic [SEG_W-1:0] seg_q,  seg_d;

  logic [PRE_W-1:0] pre_lim;
  logic [SEG_W-1:0] seg_lim;
  logic [SEG_W-1:0] mid_lim;
  logic             base_wrap;
  logic             pre_wrap;
  logic             seg_wrap;

  // stage limits from the active settings
  assign pre_lim = {PRE_W{1'b1}} >> (PRE_W - int'(n_i));
  assign seg_lim = SEG_W'((int'(m_i) + 1) * DEC - 1);
  assign mid_lim = SEG_W'((int'(m_i) + 1) * HALF_DEC - 1);

  // stage 1 wraps every THP+1 cycles, stage 2 every 2^N stage-1 wraps
  assign base_wrap = (base_q == thp_i);
  assign pre_wrap  = base_wrap && (pre_q == pre_lim);
  assign seg_wrap  = pre_wrap && (seg_q == seg_lim);

  always_comb begin
    base_d = base_q;
    pre_d  = pre_q;
    seg_d  = seg_q;
    if (!run_i) begin
      base_d = '0;
      pre_d  = '0;
      seg_d  = '0;
    end else begin
      base_d = base_wrap ? '0 : (base_q + THP_ONE);
      if (base_wrap) begin
        pre_d = pre_wrap ? '0 : (pre_q + PRE_ONE);
      end
      if (pre_wrap) begin
        seg_d = seg_wrap ? '0 : (seg_q + SEG_ONE);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pre_q  <= '0;
      seg_q  <= '0;
    end else begin
      base_q <= base_d;
      pre_q  <= pre_d;
      seg_q  <= seg_d;
    end
  end

  assign half_end_o = run_i && seg_wrap;
  assign mid_hit_o  = run_i && pre_wrap && (seg_q == mid_lim);

endmodule

// File: rtl/scl_div_phase.sv
`timescale 1ns/1ps
module scl_div_phase
  import scl_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic half_end_i,
  input  logic mid_hit_i,
  output logic scl_o,
  output logic edge_tick_o,
  output logic sample_tick_o,
  output logic period_end_o
);

  scl_phase_e phase_q, phase_d;
  logic       edge_q,  edge_d;
  logic       smp_q,   smp_d;

  always_comb begin
    phase_d = phase_q;
    edge_d  = 1'b0;
    smp_d   = 1'b0;
    if (!run_i) begin
      phase_d = PH_HIGH;
    end else begin
      if (half_end_i) begin
        phase_d = (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
        edge_d  = 1'b1;
      end
      smp_d = mid_hit_i && (phase_q == PH_HIGH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HIGH;
      edge_q  <= 1'b0;
      smp_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      edge_q  <= edge_d;
      smp_q   <= smp_d;
    end
  end

  assign scl_o         = (phase_q == PH_HIGH);
  assign edge_tick_o   = edge_q;
  assign sample_tick_o = smp_q;
  // end of the low phase closes a full period
  assign period_end_o  = half_end_i && (phase_q == PH_LOW);

endmodule

// File: rtl/scl_div.sv
`timescale 1ns/1ps
module scl_div #(
  parameter int THP_W   = 8,
  parameter int M_W     = 4,
  parameter int N_W     = 3,
  parameter int DEC     = 10,
  parameter int THP_MIN = 5,
  parameter int RST_THP = 'h18,
  parameter int RST_M   = 2,
  parameter int RST_N   = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       engine_en_i,
  input  logic       cfg_wr_i,
  input  logic       cfg_sel_i,
  input  logic [7:0] cfg_data_i,
  output logic       scl_o,
  output logic       edge_tick_o,
  output logic       sample_tick_o
);

  logic             rst_sync_n;
  logic [THP_W-1:0] act_thp;
  logic [M_W-1:0]   act_m;
  logic [N_W-1:0]   act_n;
  logic             half_end;
  logic             mid_hit;
  logic             period_end;
  logic             cfg_load;

  scl_div_rstsync #(.STAGES(2)) u_rstsync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign cfg_load = !engine_en_i || period_end;

  scl_div_cfg #(
    .THP_W(THP_W), .M_W(M_W), .N_W(N_W), .THP_MIN(THP_MIN),
    .RST_THP(RST_THP), .RST_M(RST_M), .RST_N(RST_N)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_i      (cfg_wr_i),
    .sel_i     (cfg_sel_i),
    .data_i    (cfg_data_i),
    .load_i    (cfg_load),
    .act_thp_o (act_thp),
    .act_m_o   (act_m),
    .act_n_o   (act_n)
  );

  scl_div_chain #(
    .THP_W(THP_W), .M_W(M_W), .N_W(N_W), .DEC(DEC)
  ) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .run_i      (engine_en_i),
    .thp_i      (act_thp),
    .m_i        (act_m),
    .n_i        (act_n),
    .half_end_o (half_end),
    .mid_hit_o  (mid_hit)
  );

  scl_div_phase u_phase (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .run_i         (engine_en_i),
    .half_end_i    (half_end),
    .mid_hit_i     (mid_hit),
    .scl_o         (scl_o),
    .edge_tick_o   (edge_tick_o),
    .sample_tick_o (sample_tick_o),
    .period_end_o  (period_end)
  );

endmodule

// File: rtl/scl_div_chk.sv
`timescale 1ns/1ps
module scl_div_chk #(
  parameter int THP_W   = 8,
  parameter int THP_MIN = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             scl_i,
  input logic             edge_i,
  input logic             sample_i,
  input logic [THP_W-1:0] act_thp_i,
  input logic             period_end_i
);

  // R9: a dropped enable releases SCL and silences both pulses
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_i && !edge_i && !sample_i));

  // R3: a level change while running is always flagged
  p_edge_marks_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (scl_i != $past(scl_i))) |-> edge_i);

  // R3: a flag always comes with a level change
  p_edge_has_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |-> (scl_i != $past(scl_i)));

  // R3: the edge pulse lasts one cycle
  p_edge_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> !edge_i);

  // R4: sampling happens only inside the high phase
  p_sample_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> (scl_i && !edge_i));

  // R6: the divider never runs below the high-phase floor
  p_thp_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(act_thp_i) >= THP_MIN);

  // R7: active settings hold between period boundaries while running
  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !period_end_i) |=> $stable(act_thp_i));

endmodule

bind scl_div scl_div_chk #(.THP_W(THP_W), .THP_MIN(THP_MIN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (engine_en_i),
  .scl_i        (scl_o),
  .edge_i       (edge_tick_o),
  .sample_i     (sample_tick_o),
  .act_thp_i    (act_thp),
  .period_end_i (period_end)
);

// File: tb/scl_div_bench.sv
`timescale 1ns/1ps
module scl_div_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       cfg_wr;
  logic       cfg_sel;
  logic [7:0] cfg_data;
  logic       scl;
  logic       edge_tick;
  logic       sample_tick;

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_div u_scl_div (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .engine_en_i   (en),
    .cfg_wr_i      (cfg_wr),
    .cfg_sel_i     (cfg_sel),
    .cfg_data_i    (cfg_data),
    .scl_o         (scl),
    .edge_tick_o   (edge_tick),
    .sample_tick_o (sample_tick)
  );

  // half period in cycles from the register bytes (R2, R5, R6)
  function automatic int half_len(logic [7:0] thp, logic [7:0] ctl);
    int t;
    t = (thp < 8'd5) ? 5 : int'(thp);
    return (t + 1) * (1 << ctl[2:0]) * (int'(ctl[6:3]) + 1) * 10;
  endfunction

  // expected outputs rel cycles after enable; ha for the first period, hb after
  function automatic void expect_at(int rel, int ha, int hb,
                                    output logic s, output logic e, output logic m);
    int r, h;
    if (rel < 2 * ha) begin r = rel; h = ha; end
    else begin r = rel - 2 * ha; h = hb; end
    s = ((r / h) % 2) == 0;
    e = (rel > 0) && ((r % h) == 0);
    m = (r % (2 * h)) == (h / 2);
  endfunction

  task automatic check_bit(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic sel, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // enable and compare every cycle over two periods of each setting
  task automatic run_case(string req, bit do_wr, logic [7:0] thp_a, logic [7:0] ctl_a,
                          bit chg, logic [7:0] thp_b, logic [7:0] ctl_b);
    int ha, hb, total, p, rel;
    int bad_s, bad_e, bad_m, at_s, at_e, at_m;
    logic es, ee, em, as_s, as_e, as_m;
    ha = half_len(thp_a, ctl_a);
    hb = chg ? half_len(thp_b, ctl_b) : ha;
    if (do_wr) begin
      wr_reg(1'b0, thp_a);
      wr_reg(1'b1, ctl_a);
    end
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    p = int'(cyc);
    total = 2 * ha + 2 * hb + 4;
    bad_s = 0; bad_e = 0; bad_m = 0; at_s = 0; at_e = 0; at_m = 0;
    as_s = 1'b0; as_e = 1'b0; as_m = 1'b0;
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      rel = int'(cyc) - p;
      if (chg) begin
        if (rel == 10) begin cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = thp_b; end
        if (rel == 11) begin cfg_sel = 1'b1; cfg_data = ctl_b; end
        if (rel == 12) cfg_wr = 1'b0;
      end
      expect_at(rel, ha, hb, es, ee, em);
      if (scl !== es) begin if (bad_s == 0) begin at_s = rel; as_s = scl; end bad_s++; end
      if (edge_tick !== ee) begin if (bad_e == 0) begin at_e = rel; as_e = edge_tick; end bad_e++; end
      if (sample_tick !== em) begin if (bad_m == 0) begin at_m = rel; as_m = sample_tick; end bad_m++; end
    end
    en = 1'b0;
    n_chk += 3;
    if (bad_s != 0) begin
      n_bad++;
      $display("FAIL %s scl at offset %0d: actual %0b expected %0b (%0d bad cycles, H %0d/%0d)",
               req, at_s, as_s, ~as_s, bad_s, ha, hb);
    end
    if (bad_e != 0) begin
      n_bad++;
      $display("FAIL %s edge pulse at offset %0d: actual %0b expected %0b (%0d bad cycles, H %0d/%0d)",
               req, at_e, as_e, ~as_e, bad_e, ha, hb);
    end
    if (bad_m != 0) begin
      n_bad++;
      $display("FAIL %s sample pulse at offset %0d: actual %0b expected %0b (%0d bad cycles, H %0d/%0d)",
               req, at_m, as_m, ~as_m, bad_m, ha, hb);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] tr, cr, tb2, cb2;
    int quiet_bad;
    rst_n = 1'b0; en = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_data = 8'h00;
    void'($urandom(32'h5C1D_0007));
    repeat (5) @(negedge clk);
    check_bit("R1", "scl in reset", scl, 1'b1);
    check_bit("R1", "edge in reset", edge_tick, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R1", "sample after reset", sample_tick, 1'b0);

    // R1, R2, R3, R4: reset settings give a 750-cycle half period
    run_case("R1", 1'b0, 8'h18, 8'h10, 1'b0, 8'h00, 8'h00);
    // R6: THP 2 runs as 5 -> H 180
    run_case("R6", 1'b1, 8'h02, 8'h10, 1'b0, 8'h00, 8'h00);
    // R5: bit 7 of the control byte ignored, M 1, N 1
    run_case("R5", 1'b1, 8'h07, 8'h89, 1'b0, 8'h00, 8'h00);
    // R2: N at its maximum of 7
    run_case("R2", 1'b1, 8'h05, 8'h07, 1'b0, 8'h00, 8'h00);
    // R2: M at its maximum of 15
    run_case("R2", 1'b1, 8'h05, 8'h78, 1'b0, 8'h00, 8'h00);
    // R7: reprogram during the first high phase, new timing from the next rise
    run_case("R7", 1'b1, 8'h05, 8'h00, 1'b1, 8'h09, 8'h0A);
    // R8: settings written while disabled apply at once
    run_case("R8", 1'b1, 8'h06, 8'h01, 1'b0, 8'h00, 8'h00);

    // R9: drop the enable in the low phase
    wr_reg(1'b0, 8'h05);
    wr_reg(1'b1, 8'h00);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    repeat (90) @(negedge clk);
    check_bit("R2", "scl low mid-period", scl, 1'b0);
    en = 1'b0;
    @(negedge clk);
    check_bit("R9", "scl released after disable", scl, 1'b1);
    quiet_bad = 0;
    repeat (100) begin
      @(negedge clk);
      if (scl !== 1'b1 || edge_tick !== 1'b0 || sample_tick !== 1'b0) quiet_bad++;
    end
    check_bit("R9", "idle while disabled", quiet_bad == 0, 1'b1);
    run_case("R9", 1'b0, 8'h05, 8'h00, 1'b0, 8'h00, 8'h00);

    // random settings, with every other run reprogrammed mid-period
    for (int k = 0; k < 6; k++) begin
      tr  = 8'(5 + $urandom_range(7));
      cr  = {1'($urandom_range(1)), 4'($urandom_range(3)), 3'($urandom_range(2))};
      tb2 = 8'($urandom_range(12));
      cb2 = {1'($urandom_range(1)), 4'($urandom_range(3)), 3'($urandom_range(2))};
      if (k % 2 == 1) run_case("R7", 1'b1, tr, cr, 1'b1, tb2, cb2);
      else            run_case("R2", 1'b1, tr, cr, 1'b0, 8'h00, 8'h00);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule